// File: doc/BRIEF.md
# Two-Channel Bus-Master IDE Register and Interrupt Block

This block holds the byte registers that software uses to steer a two-channel IDE bus-master controller, and it merges the interrupt requests of both channels into one active-high interrupt line. It sits on a simple byte-addressed I/O bus with a 16-byte window. Each channel owns eight bytes of that window. The low four bytes of each eight-byte group are decoded here. The high four bytes belong to a descriptor-pointer port that lives elsewhere, so this block leaves them unclaimed.

Per channel there is a command byte, a bus-master status byte and a drive-timing byte. A single mode byte is shared by both channels. It can be reached from either channel's window, and it holds the live interrupt-pending flag of each channel next to a per-channel block bit. The status byte mixes three kinds of bit: plain read-write bits, bits that are cleared by writing a one (and set by the channel), and a read-only activity flag that follows the channel. A command write is passed on to an external DMA engine through a one-cycle strobe that carries the channel number and the byte.

Reads have no side effects and return data in the same cycle as the address. Writes take effect at the clock edge on which `bus_wr` is sampled high.

Top module: `ide_bm_regs`

## Requirements
- R1: A synchronous active-low reset clears the command, mode, status and timing registers of both channels, and holds `irq` and `cmd_wr` low.
- R2: Only byte accesses (`bus_size` = 0) act. A read with `bus_size` = 1 returns 0x0000FFFF, and a read with `bus_size` of 2 or 3 returns 0xFFFFFFFF. A wider write changes no register and raises no strobe.
- R3: Address bit 3 selects channel 0 (offsets 0 to 3) or channel 1 (offsets 8 to 11). `bus_claim` is high only in those ranges. At offsets 4 to 7 and 12 to 15, `bus_claim` is low, reads return 0 and writes change nothing.
- R4: Offset 1 of either channel reaches the same shared mode byte. A bus write to it changes only bit 4 (block channel 0) and bit 5 (block channel 1). Every other bit keeps its value.
- R5: Mode bit 2 takes the level of `chan_irq_lvl[0]`, and mode bit 3 takes the level of `chan_irq_lvl[1]`, at each clock edge.
- R6: `irq` is high exactly when (mode bit 2 and not mode bit 4) or (mode bit 3 and not mode bit 5). It follows the mode register with no further register stage.
- R7: A byte write to status (offset 2) loads bits 5 and 6 from the data and clears bit 1 and bit 2 where the data bit is one, keeping them where it is zero. The write leaves bit 0 alone. Bits 3, 4 and 7 always read 0.
- R8: Status bit 0 takes `dma_active[n]` at each edge. A high `err_set[n]` sets bit 1 and a high `intr_set[n]` sets bit 2. A set wins over a clear written in the same cycle.
- R9: The timing byte at offset 3 is read-write and separate for each channel. It is also presented on `timing0` and `timing1`.
- R10: A byte write to offset 0 loads that channel's command byte. For exactly the next cycle `cmd_wr` is high, with `cmd_chan` giving the channel and `cmd_data` giving the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset into the 16-byte window |
| bus_size | input | 2 | Access width: 0 byte, 1 two bytes, 2 or 3 four bytes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data, byte in bits 7:0 |
| bus_rdata | output | DATA_W | Read data for the presented address |
| bus_claim | output | 1 | Address falls on a register of this block |
| chan_irq_lvl | input | 2 | Raw interrupt level per channel |
| dma_active | input | 2 | Per-channel transfer-active level |
| err_set | input | 2 | Per-channel error set pulse |
| intr_set | input | 2 | Per-channel interrupt-status set pulse |
| irq | output | 1 | Combined active-high interrupt |
| cmd_wr | output | 1 | One-cycle command-write strobe |
| cmd_chan | output | 1 | Channel of the last command write |
| cmd_data | output | 8 | Byte of the last command write |
| timing0 | output | 8 | Channel 0 timing byte |
| timing1 | output | 8 | Channel 1 timing byte |

## Verification
Reads are combinational, so read data and `bus_claim` are sampled a short delay after the address is driven on the falling edge, before the next rising edge. Writes, channel levels and set pulses are registered once. Their effect on a register, on `cmd_wr` and on `irq` is therefore due one rising edge later, and the bench samples it at the falling edge that follows. For `irq` and the pending bits the bench also checks the value before that edge, to show the one-cycle delay. The strobe is checked high on that first falling edge and low on the one after.

// File: rtl/ide_bm_pkg.sv
// Package: shared register selectors, bit positions and helpers for the
// two-channel bus-master IDE register block.
// Assumes a byte-addressed bus whose offset bits [1:0] pick the register.
package ide_bm_pkg;

    localparam int NUM_CH = 2;          // channels in the block
    localparam int REG_W  = 8;          // every register is one byte

    typedef enum logic [1:0] {
        RSEL_CMD  = 2'd0,
        RSEL_MODE = 2'd1,
        RSEL_STAT = 2'd2,
        RSEL_TIME = 2'd3
    } rsel_e;

    // mode byte bit positions
    localparam int MODE_PEND_LSB = 2;   // pending flags occupy bits 2..3
    localparam int MODE_BLK_LSB  = 4;   // block bits occupy bits 4..5

    // status byte bit classes
    localparam logic [REG_W-1:0] ST_RW_MASK  = 8'h60;
    localparam logic [REG_W-1:0] ST_W1C_MASK = 8'h06;
    localparam int ST_ACT_BIT = 0;
    localparam int ST_ERR_BIT = 1;
    localparam int ST_INT_BIT = 2;

    // all-ones pattern for a wide read of the given size code
    function automatic logic [31:0] wide_ones(input logic [1:0] size);
        wide_ones = (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

endpackage

// File: rtl/ide_bm_decode.sv
// Address decoder: turns a bus access into per-channel register write
// enables and a claim flag.
// Assumes offsets 0..3 and 8..11 are decoded here, bit 2 set is the
// descriptor-pointer hole, and only byte accesses may write.
module ide_bm_decode
    import ide_bm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    output logic              claim,
    output logic              chan,
    output rsel_e             rsel,
    output logic [NUM_CH-1:0] we_cmd,
    output logic [NUM_CH-1:0] we_stat,
    output logic [NUM_CH-1:0] we_time,
    output logic              we_mode
);

    localparam int CH_BIT   = 3;
    localparam int HOLE_BIT = 2;

    logic upper_zero;
    logic byte_wr;

    // purpose: reject offsets outside the 16-byte window
    generate
        if (ADDR_W > 4) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:4] == '0);
        end else begin : g_noupper
            assign upper_zero = 1'b1;
        end
    endgenerate

    // purpose: claim, channel and register select from the offset
    always_comb begin
        claim   = upper_zero && !addr[HOLE_BIT];
        chan    = addr[CH_BIT];
        rsel    = rsel_e'(addr[1:0]);
        byte_wr = wr && claim && (size == 2'd0);
    end

    // purpose: one write enable per channel register
    always_comb begin
        we_cmd  = '0;
        we_stat = '0;
        we_time = '0;
        we_mode = byte_wr && (rsel == RSEL_MODE);
        for (int c = 0; c < NUM_CH; c++) begin
            if (byte_wr && (chan == c[0])) begin
                we_cmd[c]  = (rsel == RSEL_CMD);
                we_stat[c] = (rsel == RSEL_STAT);
                we_time[c] = (rsel == RSEL_TIME);
            end
        end
    end

    a_r2_wide_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (size != 2'd0) |-> (we_cmd == '0 && we_stat == '0 && we_time == '0 && !we_mode));

    a_r3_hole_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_zero && addr[HOLE_BIT]) |-> (we_cmd == '0 && we_stat == '0 && we_time == '0 && !we_mode));

endmodule

// File: rtl/ide_bm_chan.sv
// Per-channel registers: command byte, bus-master status byte, timing byte.
// Assumes write enables come from the decoder already qualified for byte
// size; hardware set pulses override a same-cycle write-one-to-clear.
module ide_bm_chan
    import ide_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_cmd,
    input  logic             we_stat,
    input  logic             we_time,
    input  logic [REG_W-1:0] wdata,
    input  logic             dma_active,
    input  logic             err_set,
    input  logic             intr_set,
    output logic [REG_W-1:0] cmd_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] time_q
);

    logic [REG_W-1:0] rw_next;
    logic [REG_W-1:0] w1c_next;
    logic [REG_W-1:0] hw_bits;
    logic [REG_W-1:0] stat_next;

    // purpose: next status from write data, sticky bits and channel inputs
    always_comb begin
        rw_next  = we_stat ? (wdata & ST_RW_MASK) : (stat_q & ST_RW_MASK);
        w1c_next = we_stat ? (stat_q & ~wdata & ST_W1C_MASK) : (stat_q & ST_W1C_MASK);
        hw_bits  = '0;
        hw_bits[ST_ACT_BIT] = dma_active;
        hw_bits[ST_ERR_BIT] = err_set;
        hw_bits[ST_INT_BIT] = intr_set;
        stat_next = rw_next | w1c_next | hw_bits;
    end

    // purpose: register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            stat_q <= '0;
            time_q <= '0;
        end else begin
            if (we_cmd)  cmd_q  <= wdata;
            if (we_time) time_q <= wdata;
            stat_q <= stat_next;
        end
    end

    a_r8_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> stat_q[ST_ERR_BIT]);

    a_r8_intr_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        intr_set |=> stat_q[ST_INT_BIT]);

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we_stat && wdata[ST_ERR_BIT] && !err_set) |=> !stat_q[ST_ERR_BIT]);

    a_r7_act_follows: assert property (@(posedge clk) disable iff (!rst_n)
        we_stat |=> (stat_q[ST_ACT_BIT] == $past(dma_active)));

    a_r9_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_time |=> $stable(time_q));

endmodule

// File: rtl/ide_bm_irq.sv
// Shared mode byte and interrupt combiner.
// Assumes the bus may change only the block bits; pending bits track the
// channel levels every cycle; the interrupt is a pure function of the byte.
module ide_bm_irq
    import ide_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_mode,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NUM_CH-1:0] lvl,
    output logic [REG_W-1:0]  mode_q,
    output logic              irq
);

    logic [NUM_CH-1:0] blk_next;
    logic [NUM_CH-1:0] ch_req;

    // purpose: block bits from the bus, otherwise held
    always_comb begin
        blk_next = we_mode ? wdata[MODE_BLK_LSB +: NUM_CH]
                           : mode_q[MODE_BLK_LSB +: NUM_CH];
    end

    // purpose: mode byte update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= '0;
            mode_q[MODE_PEND_LSB +: NUM_CH] <= lvl;
            mode_q[MODE_BLK_LSB  +: NUM_CH] <= blk_next;
        end
    end

    // purpose: unblocked request per channel
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_req
            assign ch_req[c] = mode_q[MODE_PEND_LSB + c] && !mode_q[MODE_BLK_LSB + c];
        end
    endgenerate

    // purpose: merge requests into the single interrupt
    assign irq = |ch_req;

    a_r4_block_write: assert property (@(posedge clk) disable iff (!rst_n)
        we_mode |=> (mode_q[5:4] == $past(wdata[5:4])));

    a_r5_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_q[3:2] == $past(lvl)));

    a_r6_all_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5:4] == 2'b11) |-> !irq);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3:2] == 2'b00) |-> !irq);

endmodule

// File: rtl/ide_bm_regs.sv
// Top: two-channel bus-master IDE register block with combined interrupt.
// Assumes a single-cycle write strobe, combinational reads without side
// effects, and an external DMA engine listening to the command strobe.
module ide_bm_regs
    import ide_bm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_claim,
    input  logic [1:0]        chan_irq_lvl,
    input  logic [1:0]        dma_active,
    input  logic [1:0]        err_set,
    input  logic [1:0]        intr_set,
    output logic              irq,
    output logic              cmd_wr,
    output logic              cmd_chan,
    output logic [7:0]        cmd_data,
    output logic [7:0]        timing0,
    output logic [7:0]        timing1
);

    logic              dec_chan;
    rsel_e             dec_rsel;
    logic [NUM_CH-1:0] we_cmd, we_stat, we_time;
    logic              we_mode;
    logic [REG_W-1:0]  wbyte;
    logic [REG_W-1:0]  mode_q;
    logic [REG_W-1:0]  cmd_q  [NUM_CH];
    logic [REG_W-1:0]  stat_q [NUM_CH];
    logic [REG_W-1:0]  time_q [NUM_CH];
    logic [REG_W-1:0]  sel_byte;

    assign wbyte = bus_wdata[REG_W-1:0];

    ide_bm_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .size    (bus_size),
        .wr      (bus_wr),
        .claim   (bus_claim),
        .chan    (dec_chan),
        .rsel    (dec_rsel),
        .we_cmd  (we_cmd),
        .we_stat (we_stat),
        .we_time (we_time),
        .we_mode (we_mode)
    );

    ide_bm_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_mode (we_mode),
        .wdata   (wbyte),
        .lvl     (chan_irq_lvl),
        .mode_q  (mode_q),
        .irq     (irq)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            ide_bm_chan u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .we_cmd     (we_cmd[c]),
                .we_stat    (we_stat[c]),
                .we_time    (we_time[c]),
                .wdata      (wbyte),
                .dma_active (dma_active[c]),
                .err_set    (err_set[c]),
                .intr_set   (intr_set[c]),
                .cmd_q      (cmd_q[c]),
                .stat_q     (stat_q[c]),
                .time_q     (time_q[c])
            );
        end
    endgenerate

    assign timing0 = time_q[0];
    assign timing1 = time_q[1];

    // purpose: select the addressed byte of the addressed channel
    always_comb begin
        unique case (dec_rsel)
            RSEL_CMD:  sel_byte = cmd_q[dec_chan];
            RSEL_MODE: sel_byte = mode_q;
            RSEL_STAT: sel_byte = stat_q[dec_chan];
            default:   sel_byte = time_q[dec_chan];
        endcase
    end

    // purpose: read data with width rule and hole handling
    always_comb begin
        bus_rdata = '0;
        if (bus_claim) begin
            if (bus_size == 2'd0) bus_rdata[REG_W-1:0] = sel_byte;
            else                  bus_rdata = DATA_W'(wide_ones(bus_size));
        end
    end

    // purpose: command strobe and payload toward the DMA engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_wr   <= 1'b0;
            cmd_chan <= 1'b0;
            cmd_data <= '0;
        end else begin
            cmd_wr <= |we_cmd;
            if (|we_cmd) begin
                cmd_chan <= we_cmd[1];
                cmd_data <= wbyte;
            end
        end
    end

    a_r10_strobe_payload: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> (cmd_data == cmd_q[cmd_chan]));

    a_r10_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> $past(bus_wr && bus_size == 2'd0));

    a_r1_held_in_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!cmd_wr && !irq && mode_q == '0));

endmodule

// File: tb/ide_bm_regs_test.sv
module ide_bm_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_claim;
    logic [1:0]  chan_irq_lvl = '0;
    logic [1:0]  dma_active = '0;
    logic [1:0]  err_set = '0;
    logic [1:0]  intr_set = '0;
    logic        irq, cmd_wr, cmd_chan;
    logic [7:0]  cmd_data, timing0, timing1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ide_bm_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_claim(bus_claim), .chan_irq_lvl(chan_irq_lvl),
        .dma_active(dma_active), .err_set(err_set), .intr_set(intr_set),
        .irq(irq), .cmd_wr(cmd_wr), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
        .timing0(timing0), .timing1(timing1)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
        logic        claim;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    // write vectors: data written; read vectors: exp checked with claim
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 4'h3, 2'd0, 32'hA5, 32'h0,        1'b1, 8'd9},  // R9 timing0
        '{1'b1, 4'hB, 2'd0, 32'h3C, 32'h0,        1'b1, 8'd9},  // R9 timing1
        '{1'b0, 4'h3, 2'd0, 32'h0,  32'hA5,       1'b1, 8'd9},  // R9
        '{1'b0, 4'hB, 2'd0, 32'h0,  32'h3C,       1'b1, 8'd9},  // R9
        '{1'b1, 4'h1, 2'd0, 32'hFF, 32'h0,        1'b1, 8'd4},  // R4
        '{1'b0, 4'h9, 2'd0, 32'h0,  32'h30,       1'b1, 8'd4},  // R4 shared
        '{1'b1, 4'h2, 2'd0, 32'hFF, 32'h0,        1'b1, 8'd7},  // R7
        '{1'b0, 4'h2, 2'd0, 32'h0,  32'h60,       1'b1, 8'd7},  // R7
        '{1'b0, 4'hA, 2'd0, 32'h0,  32'h00,       1'b1, 8'd7},  // R7 other ch
        '{1'b1, 4'h3, 2'd1, 32'h1234, 32'h0,      1'b1, 8'd2},  // R2 wide wr
        '{1'b0, 4'h3, 2'd0, 32'h0,  32'hA5,       1'b1, 8'd2},  // R2
        '{1'b0, 4'h3, 2'd1, 32'h0,  32'h0000FFFF, 1'b1, 8'd2},  // R2
        '{1'b0, 4'h0, 2'd2, 32'h0,  32'hFFFFFFFF, 1'b1, 8'd2},  // R2
        '{1'b0, 4'h9, 2'd3, 32'h0,  32'hFFFFFFFF, 1'b1, 8'd2},  // R2
        '{1'b0, 4'h4, 2'd0, 32'h0,  32'h0,        1'b0, 8'd3},  // R3 hole
        '{1'b1, 4'hF, 2'd0, 32'h77, 32'h0,        1'b0, 8'd3},  // R3 hole wr
        '{1'b0, 4'hB, 2'd0, 32'h0,  32'h3C,       1'b1, 8'd3},  // R3
        '{1'b1, 4'h1, 2'd0, 32'h00, 32'h0,        1'b1, 8'd4},  // R4
        '{1'b0, 4'h1, 2'd0, 32'h0,  32'h00,       1'b1, 8'd4}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive a write on a falling edge; returns on the falling edge after it lands
    task automatic bwrite(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // combinational read sampled shortly after the address settles
    task automatic bread(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
        bus_addr = a; bus_size = s; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            if (a[2] == 1'b0) begin
                bread(4'(a), 2'd0, rd);
                chk("R1 reg after reset", rd, 32'h0);
            end
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 cmd_wr after reset", {31'b0, cmd_wr}, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                bwrite(VEC[i].addr, VEC[i].size, VEC[i].data);
            end else begin
                bread(VEC[i].addr, VEC[i].size, rd);
                chk($sformatf("R%0d vec %0d read", VEC[i].req, i), rd, VEC[i].exp);
                chk($sformatf("R%0d vec %0d claim", VEC[i].req, i), {31'b0, bus_claim}, {31'b0, VEC[i].claim});
            end
        end
        chk("R9 timing0 port", {24'b0, timing0}, 32'hA5);
        chk("R9 timing1 port", {24'b0, timing1}, 32'h3C);
        bread(4'h8, 2'd0, rd);
        chk("R3 hole write left cmd1", rd, 32'h0);

        // R5 / R6 pending and interrupt
        @(negedge clk);
        chan_irq_lvl = 2'b01;
        #1;
        chk("R5 irq before edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 irq ch0", {31'b0, irq}, 32'h1);
        bread(4'h1, 2'd0, rd);
        chk("R5 pending ch0", rd, 32'h04);
        bwrite(4'h1, 2'd0, 32'h10);
        chk("R6 ch0 blocked", {31'b0, irq}, 32'h0);
        bread(4'h9, 2'd0, rd);
        chk("R4 pending kept", rd, 32'h14);
        bwrite(4'h9, 2'd0, 32'hCF);
        bread(4'h1, 2'd0, rd);
        chk("R4 only block bits", rd, 32'h04);
        chk("R6 unblocked", {31'b0, irq}, 32'h1);
        chan_irq_lvl = 2'b11;
        bwrite(4'h1, 2'd0, 32'h10);
        chk("R6 ch1 passes", {31'b0, irq}, 32'h1);
        bread(4'h1, 2'd0, rd);
        chk("R5 both pending", rd, 32'h1C);
        bwrite(4'h1, 2'd0, 32'h30);
        chk("R6 both blocked", {31'b0, irq}, 32'h0);
        chan_irq_lvl = 2'b00;
        @(negedge clk);
        bread(4'h1, 2'd0, rd);
        chk("R5 pending cleared", rd, 32'h30);
        bwrite(4'h1, 2'd0, 32'h00);

        // R8 status hardware bits
        dma_active = 2'b10;
        @(negedge clk);
        bread(4'hA, 2'd0, rd);
        chk("R8 active bit", rd, 32'h01);
        bwrite(4'hA, 2'd0, 32'hFF);
        bread(4'hA, 2'd0, rd);
        chk("R7 bit0 kept on write", rd, 32'h61);
        err_set = 2'b10;
        @(negedge clk);
        err_set = 2'b00;
        bread(4'hA, 2'd0, rd);
        chk("R8 err set", rd, 32'h63);
        intr_set = 2'b10;
        @(negedge clk);
        intr_set = 2'b00;
        bread(4'hA, 2'd0, rd);
        chk("R8 intr set", rd, 32'h67);
        bwrite(4'hA, 2'd0, 32'h02);
        bread(4'hA, 2'd0, rd);
        chk("R7 w1c bit1", rd, 32'h05);
        @(negedge clk);
        bus_addr = 4'hA; bus_size = 2'd0; bus_wdata = 32'h04; bus_wr = 1'b1;
        intr_set = 2'b10;
        @(negedge clk);
        bus_wr = 1'b0; intr_set = 2'b00;
        bread(4'hA, 2'd0, rd);
        chk("R8 set beats clear", rd, 32'h05);
        bwrite(4'hA, 2'd0, 32'h04);
        bread(4'hA, 2'd0, rd);
        chk("R7 w1c bit2", rd, 32'h01);
        dma_active = 2'b00;

        // R10 command strobe
        bwrite(4'h8, 2'd0, 32'h09);
        chk("R10 strobe high", {31'b0, cmd_wr}, 32'h1);
        chk("R10 chan", {31'b0, cmd_chan}, 32'h1);
        chk("R10 data", {24'b0, cmd_data}, 32'h09);
        @(negedge clk);
        chk("R10 strobe one cycle", {31'b0, cmd_wr}, 32'h0);
        bread(4'h8, 2'd0, rd);
        chk("R10 cmd readback", rd, 32'h09);
        bwrite(4'h0, 2'd0, 32'h5A);
        chk("R10 chan0", {31'b0, cmd_chan}, 32'h0);
        chk("R10 data0", {24'b0, cmd_data}, 32'h5A);
        bwrite(4'h0, 2'd2, 32'hFF);
        chk("R2 wide cmd no strobe", {31'b0, cmd_wr}, 32'h0);
        bread(4'h0, 2'd0, rd);
        chk("R2 wide cmd no load", rd, 32'h5A);

        // R1 reset after activity
        chan_irq_lvl = 2'b01;
        @(negedge clk);
        chan_irq_lvl = 2'b00;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 timing0 cleared", {24'b0, timing0}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bread(4'h0, 2'd0, rd);
        chk("R1 cmd0 cleared", rd, 32'h0);
        bread(4'h2, 2'd0, rd);
        chk("R1 status0 cleared", rd, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule